// File: doc/BRIEF.md
# Time-Multiplexed Spike Switch Node

This block is one node of a two-dimensional torus or mesh that carries neuron spikes between processing elements. The node has five single-bit inputs (north, south, west, east and the local element) and five single-bit outputs in the same directions. There are no packets and no neuron IDs. Each spike is one bit on a dedicated virtual circuit, and the time slot it travels in tells the receiver which neuron fired.

In every cycle, each output forwards one of the four other inputs or sits idle. The choice comes from a schedule entry read from a local table. The table row is selected by a time-slot counter that repeats with a programmable period. As an alternative, a slot number shared by the whole array can address the table, and the node's own counter is exported so that one node can act as that shared source.

The schedule is computed offline, so the node has no buffers, no arbitration and no flow control. The spike links carry no valid/ready pair. A spike bit is presented for exactly one cycle and is consumed or lost in that same cycle, so back-pressure cannot occur. The schedule is written through a plain address, data and write-enable port.

Top module: `tms_switch`

## Requirements
- R1: Ports are numbered north=0, south=1, west=2, east=3, local=4. Output o with select code k (0..3) forwards input (o+1+k) mod 5, so an output never forwards its own-direction input.
- R2: Select codes 4 to 7 mark an unused slot, and the output then carries 0.
- R3: The local slot counter advances by one per cycle while enabled and returns to 0 after slot P-1. P is `period_len`, with 0 treated as 1 and values above MAX_PERIOD treated as MAX_PERIOD.
- R4: When `use_global_slot` is high, the table is addressed by `global_slot` instead of the local counter, and the local counter keeps running.
- R5: `spike_out` is registered. Its value in cycle t+1 is set by `spike_in` and by the table entry of the active slot in cycle t.
- R6: A configuration write stores lane o (bits 3o+2..3o of `cfg_sel`) as the select code of output o at slot `cfg_slot`. A read of that slot in the same cycle still sees the old entry, and the new entry applies from the next cycle.
- R7: Synchronous reset clears the counter to 0 and sets every table entry to idle. While `sched_en` is low, all outputs are 0 and the counter stays at 0.
- R8: Several outputs may select the same input in the same slot, so the spike is multicast to all of them.
- R9: If the period is shortened while the counter is at or beyond the new last slot, the counter returns to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sched_en | input | 1 | Runs the schedule; low forces idle outputs and counter 0 |
| period_len | input | SLOT_W+1 | Schedule period in slots |
| use_global_slot | input | 1 | Address the table with `global_slot` |
| global_slot | input | SLOT_W | Shared slot number |
| cfg_we | input | 1 | Schedule write enable |
| cfg_slot | input | SLOT_W | Slot being written |
| cfg_sel | input | 15 | Five 3-bit select codes, output 0 in the low lane |
| spike_in | input | 5 | Spike bits by port index |
| spike_out | output | 5 | Registered spike bits by port index |
| slot_cnt | output | SLOT_W | Local slot counter |

## Verification
Routing results are due one cycle after the cycle that applies them. The bench drives each input pattern on a falling edge and compares `spike_out` on the next falling edge against the table entry of the slot that was active before that rising edge. The counter value on `slot_cnt` is checked before every drive, and the bench moves its own expected slot forward using the period rule. For write timing, the bench writes a slot while that same slot is being read and expects the old route first and the new route one cycle later. After a period change, the bench expects the counter to return to 0 on the next edge.

// File: rtl/tms_pkg.sv
package tms_pkg;
  localparam int unsigned NUM_PORTS = 5;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned ENTRY_W   = NUM_PORTS * SEL_W;
  localparam int unsigned CHOICES   = NUM_PORTS - 1;

  typedef enum logic [2:0] {
    PORT_N = 3'd0,
    PORT_S = 3'd1,
    PORT_W = 3'd2,
    PORT_E = 3'd3,
    PORT_L = 3'd4
  } port_e;

  localparam logic [SEL_W-1:0]   SEL_IDLE   = '1;
  localparam logic [ENTRY_W-1:0] ENTRY_IDLE = '1;
endpackage

// File: rtl/tms_slot_counter.sv
module tms_slot_counter #(
  parameter int unsigned MAX_PERIOD = 16,
  parameter int unsigned SLOT_W     = $clog2(MAX_PERIOD),
  parameter int unsigned LEN_W      = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LEN_W-1:0]  period_len,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [LEN_W-1:0] LAST_MAX = LEN_W'(MAX_PERIOD - 1);
  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_PERIOD);

  logic [LEN_W-1:0] last_slot;

  always_comb begin
    if (period_len == '0)
      last_slot = '0;
    else if (period_len > LEN_MAX)
      last_slot = LAST_MAX;
    else
      last_slot = period_len - LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)
      slot <= '0;
    else if (LEN_W'(slot) >= last_slot)
      slot <= '0;
    else
      slot <= slot + SLOT_W'(1);
  end
endmodule

// File: rtl/tms_sched_table.sv
module tms_sched_table #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned SLOT_W  = $clog2(DEPTH),
  parameter int unsigned ENTRY_W = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [SLOT_W-1:0]  waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [SLOT_W-1:0]  raddr,
  output logic [ENTRY_W-1:0] rdata
);
  logic [ENTRY_W-1:0] rows [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++)
        rows[i] <= '1;
    end else if (we && (32'(waddr) < DEPTH)) begin
      rows[waddr] <= wdata;
    end
  end

  always_comb begin
    if (32'(raddr) < DEPTH)
      rdata = rows[raddr];
    else
      rdata = '1;
  end
endmodule

// File: rtl/tms_out_mux.sv
module tms_out_mux #(
  parameter int unsigned NUM_IN  = 5,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned OUT_IDX = 0
) (
  input  logic [NUM_IN-1:0] ins,
  input  logic [SEL_W-1:0]  sel,
  output logic              q
);
  always_comb begin
    q = 1'b0;
    for (int k = 0; k < int'(NUM_IN) - 1; k++) begin
      if (sel == SEL_W'(k))
        q = ins[(int'(OUT_IDX) + 1 + k) % int'(NUM_IN)];
    end
  end
endmodule

// File: rtl/tms_switch.sv
module tms_switch
  import tms_pkg::*;
#(
  parameter int unsigned MAX_PERIOD = 16,
  parameter int unsigned SLOT_W     = $clog2(MAX_PERIOD),
  parameter int unsigned LEN_W      = SLOT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sched_en,
  input  logic [LEN_W-1:0]     period_len,
  input  logic                 use_global_slot,
  input  logic [SLOT_W-1:0]    global_slot,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [ENTRY_W-1:0]   cfg_sel,
  input  logic [NUM_PORTS-1:0] spike_in,
  output logic [NUM_PORTS-1:0] spike_out,
  output logic [SLOT_W-1:0]    slot_cnt
);
  logic [SLOT_W-1:0]    active_slot;
  logic [ENTRY_W-1:0]   entry;
  logic [NUM_PORTS-1:0] routed;

  tms_slot_counter #(
    .MAX_PERIOD(MAX_PERIOD), .SLOT_W(SLOT_W), .LEN_W(LEN_W)
  ) u_counter (
    .clk(clk), .rst(rst), .en(sched_en),
    .period_len(period_len), .slot(slot_cnt)
  );

  assign active_slot = use_global_slot ? global_slot : slot_cnt;

  tms_sched_table #(
    .DEPTH(MAX_PERIOD), .SLOT_W(SLOT_W), .ENTRY_W(ENTRY_W)
  ) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_slot),
    .wdata(cfg_sel), .raddr(active_slot), .rdata(entry)
  );

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    tms_out_mux #(
      .NUM_IN(NUM_PORTS), .SEL_W(SEL_W), .OUT_IDX(o)
    ) u_mux (
      .ins(spike_in), .sel(entry[o*SEL_W +: SEL_W]), .q(routed[o])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !sched_en)
      spike_out <= '0;
    else
      spike_out <= routed;
  end
endmodule

// File: rtl/tms_switch_chk.sv
module tms_switch_chk #(
  parameter int unsigned MAX_PERIOD = 16,
  parameter int unsigned SLOT_W     = $clog2(MAX_PERIOD)
) (
  input logic              clk,
  input logic              rst,
  input logic              sched_en,
  input logic [4:0]        spike_in,
  input logic [4:0]        spike_out,
  input logic [SLOT_W-1:0] slot_cnt
);
  // R7: reset leaves outputs idle
  assert_idle_after_reset_R7: assert property (@(posedge clk)
    rst |=> (spike_out == '0 && slot_cnt == '0));

  // R7: disabled schedule keeps outputs idle and counter at 0
  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !sched_en |=> (spike_out == '0 && slot_cnt == '0));

  // R3: counter never leaves the table
  assert_slot_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    32'(slot_cnt) < MAX_PERIOD);

  // R3: counter steps by one or returns to 0
  assert_count_steps_R3: assert property (@(posedge clk) disable iff (rst)
    sched_en |=> (slot_cnt == $past(slot_cnt) + SLOT_W'(1)) || (slot_cnt == '0));

  // R5: no spike appears without an input spike one cycle earlier
  assert_no_spurious_spike_R5: assert property (@(posedge clk) disable iff (rst)
    (spike_in == '0) |=> (spike_out == '0));
endmodule

bind tms_switch tms_switch_chk #(.MAX_PERIOD(MAX_PERIOD), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .sched_en(sched_en), .spike_in(spike_in),
  .spike_out(spike_out), .slot_cnt(slot_cnt)
);

// File: tb/test_tms_switch.sv
module test_tms_switch;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sched_en = 1'b0;
  logic [SW:0] period_len = '0;
  logic use_global_slot = 1'b0;
  logic [SW-1:0] global_slot = '0;
  logic cfg_we = 1'b0;
  logic [SW-1:0] cfg_slot = '0;
  logic [14:0] cfg_sel = '0;
  logic [4:0] spike_in = '0;
  logic [4:0] spike_out;
  logic [SW-1:0] slot_cnt;

  int n_checks = 0;
  int n_fail = 0;
  logic [14:0] tbl [MAXP];
  int exp_slot = 0;
  int exp_last = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tms_switch #(.MAX_PERIOD(MAXP)) i_tms_switch (
    .clk(clk), .rst(rst), .sched_en(sched_en), .period_len(period_len),
    .use_global_slot(use_global_slot), .global_slot(global_slot),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_sel(cfg_sel),
    .spike_in(spike_in), .spike_out(spike_out), .slot_cnt(slot_cnt)
  );

  function automatic logic [4:0] route(logic [14:0] e, logic [4:0] in);
    logic [4:0] r = '0;
    for (int o = 0; o < 5; o++) begin
      int code = int'(e[o*3 +: 3]);
      if (code < 4) r[o] = in[(o + 1 + code) % 5];
    end
    return r;
  endfunction

  function automatic logic [14:0] lanes(int c0, int c1, int c2, int c3, int c4);
    return {3'(c4), 3'(c3), 3'(c2), 3'(c1), 3'(c0)};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_period(int p);
    period_len = (SW+1)'(p);
    exp_last = (p == 0) ? 0 : (p > MAXP ? MAXP - 1 : p - 1);
  endtask

  task automatic write_entry(int s, logic [14:0] e);
    cfg_we = 1'b1; cfg_slot = SW'(s); cfg_sel = e;
    @(negedge clk);
    cfg_we = 1'b0;
    tbl[s] = e;
  endtask

  // one cycle: check counter, drive inputs, check routed output one cycle later
  task automatic cycle(string req, logic [4:0] in);
    int rs;
    check(req, "slot_cnt", int'(slot_cnt), exp_slot);
    rs = use_global_slot ? int'(global_slot) : exp_slot;
    spike_in = in;
    @(negedge clk);
    check(req, "spike_out", int'(spike_out), sched_en ? int'(route(tbl[rs], in)) : 0);
    exp_slot = !sched_en ? 0 : (exp_slot >= exp_last ? 0 : exp_slot + 1);
  endtask

  task automatic do_reset();
    rst = 1'b1; sched_en = 1'b0; use_global_slot = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < MAXP; i++) tbl[i] = '1;
    exp_slot = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R7", "out after reset", int'(spike_out), 0);
    check("R7", "slot after reset", int'(slot_cnt), 0);
    set_period(4);
    cycle("R7", 5'h1F);
    cycle("R7", 5'h15);
    // schedule is idle after reset even when enabled
    sched_en = 1'b1;
    cycle("R7", 5'h1F);
    cycle("R7", 5'h1F);
    sched_en = 1'b0; exp_slot = 0;
    @(negedge clk);
  endtask

  task automatic t_routing();
    do_reset();
    for (int s = 0; s < 4; s++) write_entry(s, lanes(s, s, s, s, s));
    set_period(4);
    sched_en = 1'b1;
    for (int i = 0; i < 12; i++) cycle("R1", 5'(1 << (i % 5)));
    cycle("R5", 5'h0A);
    cycle("R5", 5'h1B);
    sched_en = 1'b0; @(negedge clk); exp_slot = 0;
  endtask

  task automatic t_idle_codes();
    do_reset();
    write_entry(0, lanes(4, 5, 6, 7, 0));
    write_entry(1, lanes(0, 7, 1, 4, 2));
    set_period(2);
    sched_en = 1'b1;
    for (int i = 0; i < 4; i++) cycle("R2", 5'h1F);
    sched_en = 1'b0; @(negedge clk); exp_slot = 0;
  endtask

  task automatic t_multicast();
    do_reset();
    // outputs 0..3 all take the local input (index 4)
    write_entry(0, lanes(3, 2, 1, 0, 7));
    set_period(1);
    sched_en = 1'b1;
    cycle("R8", 5'h10);
    check("R8", "fan-out", int'(spike_out), 5'h0F);
    cycle("R8", 5'h0F);
    sched_en = 1'b0; @(negedge clk); exp_slot = 0;
  endtask

  task automatic t_wrap();
    do_reset();
    sched_en = 1'b1;
    set_period(5);
    for (int i = 0; i < 12; i++) cycle("R3", 5'h00);
    set_period(0);
    for (int i = 0; i < 3; i++) cycle("R3", 5'h00);
    set_period(20);
    for (int i = 0; i < 20; i++) cycle("R3", 5'h00);
    sched_en = 1'b0; @(negedge clk); exp_slot = 0;
  endtask

  task automatic t_shrink();
    do_reset();
    sched_en = 1'b1;
    set_period(8);
    while (exp_slot != 6) cycle("R9", 5'h00);
    set_period(4);
    cycle("R9", 5'h00);
    check("R9", "slot after shrink", int'(slot_cnt), 0);
    for (int i = 0; i < 5; i++) cycle("R9", 5'h00);
    sched_en = 1'b0; @(negedge clk); exp_slot = 0;
  endtask

  task automatic t_global();
    do_reset();
    for (int s = 0; s < 8; s++) write_entry(s, lanes(s % 4, (s + 1) % 4, (s + 2) % 4, (s + 3) % 4, s % 5));
    set_period(3);
    sched_en = 1'b1;
    use_global_slot = 1'b1;
    for (int i = 0; i < 10; i++) begin
      global_slot = SW'((i * 3) % 8);
      cycle("R4", 5'(i * 7 + 3));
    end
    use_global_slot = 1'b0;
    sched_en = 1'b0; @(negedge clk); exp_slot = 0;
  endtask

  task automatic t_write_timing();
    logic [14:0] old_e, new_e;
    do_reset();
    old_e = lanes(0, 0, 0, 0, 0);
    new_e = lanes(1, 2, 3, 0, 1);
    write_entry(0, old_e);
    set_period(1);
    sched_en = 1'b1;
    cycle("R6", 5'h05);
    // write slot 0 while slot 0 is being read
    cfg_we = 1'b1; cfg_slot = '0; cfg_sel = new_e;
    spike_in = 5'h13;
    @(negedge clk);
    check("R6", "old entry same cycle", int'(spike_out), int'(route(old_e, 5'h13)));
    cfg_we = 1'b0;
    tbl[0] = new_e;
    cycle("R6", 5'h13);
    check("R6", "new entry", int'(spike_out), int'(route(new_e, 5'h13)));
    sched_en = 1'b0; @(negedge clk); exp_slot = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_routing();
    t_idle_codes();
    t_multicast();
    t_wrap();
    t_shrink();
    t_global();
    t_write_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule